// File: doc/BRIEF.md
# Serial Flash Read-Command Front-End

This block is the slave-side serial engine of a byte-addressed serial flash. It works in clock mode 0: it captures SI on each rising SCK, updates SO after each falling SCK, and moves the most significant bit first. The first byte after chip select falls is taken as an opcode. The block then runs the phases of four commands: array read, array read with a dummy byte, status read and identification read. It runs no program, erase or protection logic. Every other opcode leaves the interface silent until the next selection.

The serial pins are sampled in the system clock domain, which runs faster than SCK. Array data comes from a synchronous memory port. The block issues one request pulse one bit-time before each data byte goes out, and reads the returned byte one cycle later. Status comes from a live 8-bit input. The three identification bytes are parameters. A pause input freezes a transfer without losing its place. SO is returned with a separate output enable, so that the pad can be put in high-Z.

Top module: `spi_flash_front`

## Requirements
- R1: SI is taken on rising SCK and SO changes only after falling SCK, MSB first. SO holds its value while SCK is high. SCK high and low phases each last at least 4 clk_i cycles.
- R2: The first byte after CS falls is the opcode. Opcode 03h is followed by three address bytes, MSB first. Data bytes are then driven from the next falling SCK. SO is high-Z during the opcode and the address.
- R3: During a read, the byte address rises by one per byte. After address 7FFFFh it continues at 00000h with no gap.
- R4: Address bits 23..19 are ignored, and mem_addr_o carries bits 18..0.
- R5: Opcode 0Bh takes three address bytes and then one dummy byte. SO is high-Z for the whole dummy byte, and data follows it exactly as for 03h.
- R6: mem_req_o is a one-cycle pulse. It fires at the rising SCK of the last bit of the final address byte (03h), of the dummy byte (0Bh), and of every data byte. A read in which N bytes are fully clocked therefore issues N+1 requests. mem_rdata_i must be valid in the cycle after the pulse.
- R7: An opcode with (opcode AND F7h) = 05h returns status_i. status_i is sampled again at the start of every output byte, as long as CS stays low.
- R8: Opcodes 9Fh and ABh return the bytes 1Fh, 66h, 04h (parameters), repeating in that order while CS stays low.
- R9: Any other opcode makes the block take no further input and issue no request. SO stays high-Z until CS falls again.
- R10: HOLD low while SCK is low pauses the transfer. While paused, SO is high-Z and SCK and SI are ignored. HOLD high while SCK is low resumes the transfer with its position kept.
- R11: While CS is high, SO is high-Z and the sequence ends. The next CS fall starts a fresh opcode.
- R12: Under reset, so_oe_o and mem_req_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; serial pins are sampled with it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, mode 0 |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO; 0 means high-Z |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 19 | Byte address of the request |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |
| status_i | input | 8 | Status byte source |

## Verification
The SCK edge detector adds one clk_i cycle. A rising edge therefore shows up on mem_req_o one cycle later, and the requested byte sits in the holding register three cycles after that edge. A falling edge changes SO one cycle after the edge. The bench holds each SCK phase for four clk_i cycles. It samples SO and its enable on the falling clk_i edge just before it raises SCK, so every result is at least three cycles old when it is read. Each bit is sampled a second time while SCK is high, to show that SO did not move. Enable checks during HOLD are taken three cycles after the pause is applied, once the pause register has settled.

// File: rtl/spi_flash_front_pkg.sv
package spi_flash_front_pkg;
  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_DATA, PH_STAT, PH_ID, PH_DEAD
  } phase_e;

  localparam int          ADDR_BYTES  = 3;
  localparam int          FIELD_W     = 8 * ADDR_BYTES;
  localparam logic [7:0]  OPC_READ    = 8'h03;
  localparam logic [7:0]  OPC_FAST    = 8'h0B;
  localparam logic [7:0]  OPC_ID_A    = 8'h9F;
  localparam logic [7:0]  OPC_ID_B    = 8'hAB;
  localparam logic [7:0]  OPC_STAT    = 8'h05;
  localparam logic [7:0]  STAT_MASK   = 8'hF7;

  function automatic phase_e decode_opc(logic [7:0] opc);
    if (opc == OPC_READ || opc == OPC_FAST)          return PH_ADDR;
    else if ((opc & STAT_MASK) == OPC_STAT)          return PH_STAT;
    else if (opc == OPC_ID_A || opc == OPC_ID_B)     return PH_ID;
    else                                             return PH_DEAD;
  endfunction
endpackage

// File: rtl/spi_flash_front_pins.sv
module spi_flash_front_pins (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  output logic rise_o,
  output logic fall_o,
  output logic paused_o
);
  logic sck_q, paused_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      sck_q <= sck_i;
      // pause state only moves while SCK is low
      if (!sck_i) paused_q <= !hold_ni;
    end
  end

  assign rise_o   = !cs_ni && !paused_q &&  sck_i && !sck_q;
  assign fall_o   = !cs_ni && !paused_q && !sck_i &&  sck_q;
  assign paused_o = paused_q;

  p_pause_enter_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(paused_q) |-> $past(!sck_i));
  p_pause_leave_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(paused_q) |-> $past(!sck_i));
endmodule

// File: rtl/spi_flash_front_ctrl.sv
module spi_flash_front_ctrl
  import spi_flash_front_pkg::*;
#(
  parameter int         ADDR_W  = 19,
  parameter logic [7:0] ID_MFR  = 8'h1F,
  parameter logic [7:0] ID_TYPE = 8'h66,
  parameter logic [7:0] ID_CAP  = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              si_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              tx_load_o,
  output logic [7:0]        tx_byte_o
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [1:0] LAST_ADDR_BYTE = 2'(ADDR_BYTES - 1);

  phase_e              phase_q;
  logic [2:0]          bit_q;
  logic [1:0]          byte_q, id_q;
  logic [FIELD_W-1:0]  shift_q, shift_nx;
  logic [ADDR_W-1:0]   rd_addr_q, req_addr_q;
  logic                req_q, req_d1_q, fast_q;
  logic [7:0]          data_q, id_byte;
  logic                last_bit, out_phase;

  assign shift_nx  = {shift_q[FIELD_W-2:0], si_i};
  assign last_bit  = (bit_q == 3'd7);
  assign out_phase = (phase_q == PH_DATA) || (phase_q == PH_STAT) || (phase_q == PH_ID);
  assign tx_load_o = fall_i && (bit_q == 3'd0) && out_phase;

  always_comb begin
    unique case (id_q)
      2'd0:    id_byte = ID_MFR;
      2'd1:    id_byte = ID_TYPE;
      default: id_byte = ID_CAP;
    endcase
  end

  always_comb begin
    unique case (phase_q)
      PH_STAT: tx_byte_o = status_i;
      PH_ID:   tx_byte_o = id_byte;
      default: tx_byte_o = data_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_OPC;
      bit_q      <= '0;
      byte_q     <= '0;
      id_q       <= '0;
      shift_q    <= '0;
      rd_addr_q  <= '0;
      req_addr_q <= '0;
      req_q      <= 1'b0;
      req_d1_q   <= 1'b0;
      fast_q     <= 1'b0;
      data_q     <= '0;
    end else if (cs_ni) begin
      phase_q  <= PH_OPC;
      bit_q    <= '0;
      byte_q   <= '0;
      id_q     <= '0;
      req_q    <= 1'b0;
      req_d1_q <= 1'b0;
      fast_q   <= 1'b0;
    end else begin
      req_q    <= 1'b0;
      req_d1_q <= req_q;
      if (req_d1_q) data_q <= mem_rdata_i;
      if (rise_i) begin
        bit_q <= bit_q + 3'd1;
        unique case (phase_q)
          PH_OPC: begin
            shift_q <= shift_nx;
            if (last_bit) begin
              phase_q <= decode_opc(shift_nx[7:0]);
              fast_q  <= (shift_nx[7:0] == OPC_FAST);
            end
          end
          PH_ADDR: begin
            shift_q <= shift_nx;
            if (last_bit) begin
              byte_q <= byte_q + 2'd1;
              if (byte_q == LAST_ADDR_BYTE) begin
                if (fast_q) begin
                  phase_q   <= PH_DUMMY;
                  rd_addr_q <= shift_nx[ADDR_W-1:0];
                end else begin
                  phase_q    <= PH_DATA;
                  req_q      <= 1'b1;
                  req_addr_q <= shift_nx[ADDR_W-1:0];
                  rd_addr_q  <= shift_nx[ADDR_W-1:0] + ONE;
                end
              end
            end
          end
          PH_DUMMY, PH_DATA: begin
            if (last_bit) begin
              phase_q    <= PH_DATA;
              req_q      <= 1'b1;
              req_addr_q <= rd_addr_q;
              rd_addr_q  <= rd_addr_q + ONE;  // natural wrap at top of array
            end
          end
          default: ;
        endcase
      end
      if (tx_load_o && phase_q == PH_ID)
        id_q <= (id_q == 2'd2) ? 2'd0 : id_q + 2'd1;
    end
  end

  assign mem_req_o  = req_q;
  assign mem_addr_o = req_addr_q;

  p_req_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  p_req_in_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (phase_q == PH_DATA));
  p_dead_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DEAD && !cs_ni) |=> (phase_q == PH_DEAD));
  p_dead_no_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DEAD) |-> !mem_req_o);
endmodule

// File: rtl/spi_flash_front_tx.sv
module spi_flash_front_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       paused_i,
  input  logic       fall_i,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       so_o,
  output logic       so_oe_o
);
  logic [7:0] sr_q;
  logic       valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      valid_q <= 1'b0;
    end else if (cs_ni) begin
      valid_q <= 1'b0;
    end else if (fall_i) begin
      if (load_i) begin
        sr_q    <= byte_i;
        valid_q <= 1'b1;
      end else begin
        sr_q <= {sr_q[6:0], 1'b0};
      end
    end
  end

  assign so_o    = sr_q[7];
  assign so_oe_o = valid_q && !paused_i && !cs_ni;

  p_so_on_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(sr_q));
endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
  parameter int         ADDR_W  = 19,
  parameter logic [7:0] ID_MFR  = 8'h1F,
  parameter logic [7:0] ID_TYPE = 8'h66,
  parameter logic [7:0] ID_CAP  = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              hold_ni,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic [7:0]        status_i
);
  logic       rise, fall, paused, tx_load;
  logic [7:0] tx_byte;

  spi_flash_front_pins u_pins (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .hold_ni,
    .rise_o(rise), .fall_o(fall), .paused_o(paused)
  );

  spi_flash_front_ctrl #(
    .ADDR_W(ADDR_W), .ID_MFR(ID_MFR), .ID_TYPE(ID_TYPE), .ID_CAP(ID_CAP)
  ) u_ctrl (
    .clk_i, .rst_ni, .cs_ni, .rise_i(rise), .fall_i(fall), .si_i,
    .status_i, .mem_rdata_i, .mem_req_o, .mem_addr_o,
    .tx_load_o(tx_load), .tx_byte_o(tx_byte)
  );

  spi_flash_front_tx u_tx (
    .clk_i, .rst_ni, .cs_ni, .paused_i(paused), .fall_i(fall),
    .load_i(tx_load), .byte_i(tx_byte), .so_o, .so_oe_o
  );

  p_cs_hiz_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !so_oe_o);
  p_reset_quiet_r12: assert property (@(posedge clk_i)
    !rst_ni |-> (!so_oe_o && !mem_req_o));
endmodule

// File: tb/spi_flash_front_tb.sv
module spi_flash_front_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, mem_req;
  logic [18:0] mem_addr;
  logic [7:0]  mem_rdata = '0, status = 8'hA5;

  int n_chk = 0, n_err = 0, req_cnt = 0, so_moved = 0;
  logic [18:0] first_req_addr;
  bit done = 0;

  always #4 clk = ~clk;

  spi_flash_front u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .hold_ni(hold_n), .so_o(so), .so_oe_o(so_oe), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .status_i(status)
  );

  function automatic logic [7:0] patt(logic [18:0] a);
    return a[7:0] ^ {a[18:16], a[12:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= patt(mem_addr);
      if (req_cnt == 0) first_req_addr <= mem_addr;
      req_cnt <= req_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic o, output logic oe);
    @(negedge clk); si = b;
    repeat (3) @(negedge clk);
    o = so; oe = so_oe;
    sck = 1'b1;
    repeat (2) @(negedge clk);
    if (so_oe && so !== o) so_moved++;
    repeat (2) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output int oe_cnt);
    logic o, oe;
    oe_cnt = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_io(tx[i], o, oe);
      rx[i] = o;
      if (oe) oe_cnt++;
    end
  endtask

  task automatic sel;
    @(negedge clk); cs_n = 1'b0; req_cnt = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel;
    @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_addr(input logic [23:0] a, output int oe_tot);
    logic [7:0] rx; int oc;
    oe_tot = 0;
    for (int k = 2; k >= 0; k--) begin
      xfer(a[8*k +: 8], rx, oc);
      oe_tot += oc;
    end
  endtask

  task automatic t_reset;
    chk("R12 reset so_oe", so_oe, 0);
    chk("R12 reset req", mem_req, 0);
  endtask

  task automatic t_read;
    logic [7:0] rx; int oc, oa;
    sel();
    xfer(8'h03, rx, oc);
    chk("R2 opcode hiz", oc, 0);
    send_addr(24'h012345, oa);
    chk("R2 address hiz", oa, 0);
    for (int n = 0; n < 3; n++) begin
      xfer(8'h00, rx, oc);
      chk("R2 R3 read data", rx, patt(19'h12345 + 19'(n)));
      chk("R2 data oe", oc, 8);
    end
    chk("R6 request count", req_cnt, 4);
    chk("R6 first request address", first_req_addr, 19'h12345);
    chk("R1 SO stable while SCK high", so_moved, 0);
    desel();
    chk("R11 hiz after CS", so_oe, 0);
  endtask

  task automatic t_upper_bits;
    logic [7:0] rx; int oc, oa;
    sel();
    xfer(8'h03, rx, oc);
    send_addr(24'hF80010, oa);
    xfer(8'h00, rx, oc);
    chk("R4 upper bits ignored", rx, patt(19'h00010));
    chk("R4 request address", first_req_addr, 19'h00010);
    desel();
  endtask

  task automatic t_wrap;
    logic [7:0] rx; int oc, oa;
    logic [18:0] exp_a [4] = '{19'h7FFFE, 19'h7FFFF, 19'h00000, 19'h00001};
    sel();
    xfer(8'h03, rx, oc);
    send_addr(24'h07FFFE, oa);
    for (int n = 0; n < 4; n++) begin
      xfer(8'h00, rx, oc);
      chk("R3 wrap data", rx, patt(exp_a[n]));
    end
    desel();
  endtask

  task automatic t_fast;
    logic [7:0] rx; int oc, oa;
    sel();
    xfer(8'h0B, rx, oc);
    send_addr(24'h000100, oa);
    xfer(8'hFF, rx, oc);
    chk("R5 dummy hiz", oc, 0);
    chk("R6 request at dummy end", req_cnt, 1);
    for (int n = 0; n < 2; n++) begin
      xfer(8'h00, rx, oc);
      chk("R5 fast data", rx, patt(19'h00100 + 19'(n)));
    end
    desel();
  endtask

  task automatic t_status;
    logic [7:0] rx; int oc;
    status = 8'hA5;
    sel();
    xfer(8'h05, rx, oc);
    xfer(8'h00, rx, oc);
    chk("R7 status 05h", rx, 8'hA5);
    desel();
    sel();
    xfer(8'h0D, rx, oc);
    xfer(8'h00, rx, oc);
    chk("R7 status 0Dh alias", rx, 8'hA5);
    status = 8'h3C;
    xfer(8'h00, rx, oc);
    chk("R7 status resampled", rx, 8'h3C);
    desel();
  endtask

  task automatic t_id(input logic [7:0] opc, input int nbytes);
    logic [7:0] rx; int oc;
    logic [7:0] ids [3] = '{8'h1F, 8'h66, 8'h04};
    sel();
    xfer(opc, rx, oc);
    for (int n = 0; n < nbytes; n++) begin
      xfer(8'h00, rx, oc);
      chk("R8 id byte", rx, ids[n % 3]);
    end
    desel();
  endtask

  task automatic t_invalid;
    logic [7:0] rx; int oc, tot;
    sel();
    xfer(8'hFF, rx, oc);
    tot = 0;
    for (int n = 0; n < 3; n++) begin
      xfer(8'h05, rx, oc);
      tot += oc;
    end
    chk("R9 invalid opcode keeps hiz", tot, 0);
    chk("R9 invalid opcode no request", req_cnt, 0);
    desel();
    sel();
    xfer(8'h05, rx, oc);
    xfer(8'h00, rx, oc);
    chk("R11 fresh opcode after CS", rx, status);
    desel();
  endtask

  task automatic pause_toggle(input string tag);
    @(negedge clk); hold_n = 1'b0; si = 1'b1;
    repeat (3) @(negedge clk);
    chk(tag, so_oe, 0);
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; repeat (4) @(negedge clk);
      sck = 1'b0; repeat (4) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_hold;
    logic [7:0] rx; int oc, oa;
    sel();
    xfer(8'h03, rx, oc);
    xfer(8'h00, rx, oc);
    pause_toggle("R10 hiz in address pause");
    xfer(8'h02, rx, oc);
    xfer(8'h00, rx, oc);
    xfer(8'h00, rx, oc);
    chk("R10 data after address pause", rx, patt(19'h00200));
    pause_toggle("R10 hiz in data pause");
    xfer(8'h00, rx, oc);
    chk("R10 data after data pause", rx, patt(19'h00201));
    desel();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_read();
    t_upper_bits();
    t_wrap();
    t_fast();
    t_status();
    t_id(8'h9F, 6);
    t_id(8'hAB, 3);
    t_invalid();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule